// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers sixteen external request wires into one processor interrupt. It contains two eight-input priority units. The secondary unit serves lines 8 to 15, and its interrupt output feeds input 2 of the primary unit. That link takes one input, which leaves fifteen usable lines. External line 2 is not lost: any request on it is steered into line 9 of the secondary unit. Older software that still uses line 2 therefore keeps working, and it sees vector base+9.

Each unit latches rising edges as pending requests. It skips any line that is masked, and it compares the best remaining request with the levels already in service. The processor receives one interrupt output. When the processor pulses the acknowledge input, the winning request moves from pending to in-service, and a vector number appears for one cycle. The handler ends with an end-of-interrupt command to the unit that owns the level. A handler for a line served through the cascade needs this command on both units. A status port reads back the pending, in-service or mask bits of both units.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset the pending, in-service and mask bits of both units are clear, `int_out` is low and `vec_valid` is low.
- R2: A rising edge on a request line, seen at a clock edge, sets that line's pending bit. Acknowledging the line clears the bit. A line held high after its acknowledge does not set the bit again until it falls and rises.
- R3: The fixed priority runs from line 0 (highest) through line 1, then lines 8 to 15 through the cascade input, then lines 3 to 7 (lowest). An acknowledge always serves the highest-priority line that is eligible.
- R4: An acknowledge sampled at a clock edge drives `vec` = VEC_BASE + line number with `vec_valid` high during the next cycle only. The served line becomes in-service in the primary unit, and also in the secondary unit when the line is 8 to 15.
- R5: `int_out` is high exactly when some unmasked pending request has strictly higher priority than every in-service level of its unit. A request of equal or lower priority stays pending and does not raise `int_out`.
- R6: `eoi_pri` clears the highest-priority in-service bit of the primary unit, and `eoi_sec` does the same for the secondary unit. After a line from 8 to 15 is served, lower lines stay blocked until both commands have been given.
- R7: A set mask bit keeps its line from raising `int_out` while its edge is still latched as pending. Clearing the mask lets the held request raise `int_out`. `mask_sel` = 0 writes the primary mask and `mask_sel` = 1 writes the secondary mask.
- R8: A rising edge on external line 2 is recorded as line 9. It shows as status bit 9 and is served with vector VEC_BASE+9.
- R9: An acknowledge with no eligible request changes no state and returns VEC_BASE+7.
- R10: The encoding of `stat_sel` is 0 for pending, 1 for in-service, 2 for mask and 3 for all zeros. `stat_data[7:0]` is the primary unit and `stat_data[15:8]` is the secondary unit. Primary bit 2 shows the cascade input: as pending it follows the secondary interrupt, and as in-service it marks a level served through the cascade.
- R11: An acknowledge and an end-of-interrupt in the same cycle both take effect. The new level is set and the previous highest level is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Request lines; bit 2 is steered to line 9 |
| mask_wr | input | 1 | Mask write strobe |
| mask_sel | input | 1 | Mask target: 0 primary, 1 secondary |
| mask_data | input | 8 | Mask value; a 1 blocks its line |
| inta | input | 1 | Acknowledge pulse from the processor |
| eoi_pri | input | 1 | End-of-interrupt for the primary unit |
| eoi_sec | input | 1 | End-of-interrupt for the secondary unit |
| stat_sel | input | 2 | Status select |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid strobe |
| vec | output | 8 | Vector number |
| stat_data | output | 16 | Status readback |

## Verification
The two functions that can meet in the same cycle are the acknowledge of a new, higher-priority request and the end-of-interrupt that retires an older handler. Either one alone only adds or only removes a single in-service bit. The bench first leaves line 6 in service and then latches line 1. It then pulses `inta` and `eoi_pri` together in a single cycle. It expects vector base+1 from the scoreboard, and it expects the in-service readback to show only line 1, which proves that the clear and the set were merged and that neither was dropped.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int UNIT_W    = 8;
    localparam int IDX_W     = $clog2(UNIT_W);
    localparam int LINES     = 2 * UNIT_W;
    localparam int CASC_PIN  = 2;
    localparam int REDIR_SRC = 2;
    localparam int REDIR_DST = 9;

    typedef logic [UNIT_W-1:0] lvec_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef enum logic [1:0] {
        STAT_REQ  = 2'd0,
        STAT_SVC  = 2'd1,
        STAT_MSK  = 2'd2,
        STAT_NONE = 2'd3
    } stat_sel_t;

    // lowest set index wins (index 0 is highest priority)
    function automatic pick_t first_set(lvec_t v);
        pick_t p;
        p = '0;
        for (int i = UNIT_W - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = IDX_W'(i);
            end
        end
        return p;
    endfunction

    // bit i set when no in-service level at or above priority i
    function automatic lvec_t outrank(lvec_t svc);
        lvec_t r;
        logic  busy;
        busy = 1'b0;
        for (int i = 0; i < UNIT_W; i++) begin
            busy = busy | svc[i];
            r[i] = ~busy;
        end
        return r;
    endfunction

    function automatic lvec_t onehot(pick_t p);
        return p.hit ? (lvec_t'(1) << p.idx) : '0;
    endfunction
endpackage

// File: rtl/irqc_req_latch.sv
module irqc_req_latch
    import irqc_pkg::*;
#(
    parameter lvec_t LEVEL_MAP = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  lvec_t lines,
    input  lvec_t clr,
    output lvec_t req
);
    lvec_t prev_q;
    lvec_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= lines;
            pend_q <= ((pend_q & ~clr) | (lines & ~prev_q)) & ~LEVEL_MAP;
        end
    end

    // level-mapped bits follow their wire directly (cascade input)
    assign req = (pend_q & ~LEVEL_MAP) | (lines & LEVEL_MAP);
endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
    import irqc_pkg::*;
#(
    parameter lvec_t LEVEL_MAP = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  lvec_t lines,
    input  logic  mask_we,
    input  lvec_t mask_d,
    input  logic  ack,
    input  logic  eoi,
    output logic  int_o,
    output pick_t pick_o,
    output lvec_t req_o,
    output lvec_t svc_o,
    output lvec_t msk_o
);
    lvec_t imr_q;
    lvec_t isr_q;
    lvec_t req;
    lvec_t eligible;
    lvec_t ack_set;
    lvec_t eoi_clr;
    pick_t pick;

    irqc_req_latch #(.LEVEL_MAP(LEVEL_MAP)) u_req (
        .clk   (clk),
        .rst   (rst),
        .lines (lines),
        .clr   (ack_set),
        .req   (req)
    );

    always_comb begin
        eligible = req & ~imr_q & outrank(isr_q);
        pick     = first_set(eligible);
        ack_set  = ack ? onehot(pick) : '0;
        eoi_clr  = eoi ? onehot(first_set(isr_q)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
            imr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~eoi_clr) | ack_set;
            if (mask_we) imr_q <= mask_d;
        end
    end

    assign int_o  = pick.hit;
    assign pick_o = pick;
    assign req_o  = req;
    assign svc_o  = isr_q;
    assign msk_o  = imr_q;

    // served line is in service one cycle later
    assert_ack_to_service_R4: assert property (@(posedge clk) disable iff (rst)
        (ack && int_o) |=> isr_q[$past(pick.idx)]);

    // an end-of-interrupt alone retires exactly one level
    assert_eoi_retires_one_R6: assert property (@(posedge clk) disable iff (rst)
        (eoi && !ack && (|isr_q)) |=>
        ($countones(isr_q) == $countones($past(isr_q)) - 1));

    // masked requests never drive the interrupt
    assert_masked_silent_R7: assert property (@(posedge clk) disable iff (rst)
        int_o |-> (|(req & ~imr_q)));

    // acknowledge without a winner leaves service state alone
    assert_spurious_no_change_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_o && !eoi) |=> (isr_q == $past(isr_q)));
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irqc_pkg::*;
#(
    parameter logic [7:0] VEC_BASE = 8'h20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] irq_in,
    input  logic        mask_wr,
    input  logic        mask_sel,
    input  logic [7:0]  mask_data,
    input  logic        inta,
    input  logic        eoi_pri,
    input  logic        eoi_sec,
    input  logic [1:0]  stat_sel,
    output logic        int_out,
    output logic        vec_valid,
    output logic [7:0]  vec,
    output logic [15:0] stat_data
);
    localparam lvec_t PRI_LEVEL = lvec_t'(1) << CASC_PIN;

    lvec_t     sec_lines, pri_lines;
    lvec_t     sec_req, sec_svc, sec_msk;
    lvec_t     pri_req, pri_svc, pri_msk;
    pick_t     sec_pick, pri_pick;
    logic      sec_int, pri_int, sec_ack, via_casc;
    logic [7:0] vec_d, vec_q;
    logic      vv_q;
    stat_sel_t sel;

    always_comb begin
        sec_lines = irq_in[LINES-1:UNIT_W];
        sec_lines[REDIR_DST-UNIT_W] = irq_in[REDIR_DST] | irq_in[REDIR_SRC];
        pri_lines = irq_in[UNIT_W-1:0];
        pri_lines[CASC_PIN] = sec_int;
    end

    assign via_casc = pri_pick.hit && (pri_pick.idx == IDX_W'(CASC_PIN));
    assign sec_ack  = inta && via_casc;

    irqc_unit #(.LEVEL_MAP('0)) u_sec (
        .clk(clk), .rst(rst), .lines(sec_lines),
        .mask_we(mask_wr && mask_sel), .mask_d(mask_data),
        .ack(sec_ack), .eoi(eoi_sec),
        .int_o(sec_int), .pick_o(sec_pick),
        .req_o(sec_req), .svc_o(sec_svc), .msk_o(sec_msk)
    );

    irqc_unit #(.LEVEL_MAP(PRI_LEVEL)) u_pri (
        .clk(clk), .rst(rst), .lines(pri_lines),
        .mask_we(mask_wr && !mask_sel), .mask_d(mask_data),
        .ack(inta), .eoi(eoi_pri),
        .int_o(pri_int), .pick_o(pri_pick),
        .req_o(pri_req), .svc_o(pri_svc), .msk_o(pri_msk)
    );

    always_comb begin
        if (!pri_pick.hit)
            vec_d = VEC_BASE + 8'(UNIT_W - 1);
        else if (via_casc)
            vec_d = VEC_BASE + 8'(UNIT_W) +
                    (sec_pick.hit ? 8'(sec_pick.idx) : 8'(UNIT_W - 1));
        else
            vec_d = VEC_BASE + 8'(pri_pick.idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vv_q  <= 1'b0;
            vec_q <= '0;
        end else begin
            vv_q <= inta;
            if (inta) vec_q <= vec_d;
        end
    end

    always_comb begin
        sel = stat_sel_t'(stat_sel);
        unique case (sel)
            STAT_REQ: stat_data = {sec_req, pri_req};
            STAT_SVC: stat_data = {sec_svc, pri_svc};
            STAT_MSK: stat_data = {sec_msk, pri_msk};
            default:  stat_data = '0;
        endcase
    end

    assign int_out   = pri_int;
    assign vec_valid = vv_q;
    assign vec       = vec_q;

    // a vector appears only after an acknowledge
    assert_vec_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(inta));

    // secondary levels enter service only through an acknowledge
    assert_sec_entry_by_ack_R3: assert property (@(posedge clk) disable iff (rst)
        (|(sec_svc & ~$past(sec_svc))) |-> $past(inta));

    // secondary in service implies cascade level in service on the primary
    assert_casc_nesting_R6: assert property (@(posedge clk) disable iff (rst)
        ((|sec_svc) && !$past(eoi_pri)) |-> pri_svc[CASC_PIN]);
endmodule

// File: tb/sim_irq_cascade_ctrl.sv
module sim_irq_cascade_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_in = '0;
    logic        mask_wr = 1'b0, mask_sel = 1'b0;
    logic [7:0]  mask_data = '0;
    logic        inta = 1'b0, eoi_pri = 1'b0, eoi_sec = 1'b0;
    logic [1:0]  stat_sel = 2'd0;
    logic        int_out, vec_valid;
    logic [7:0]  vec;
    logic [15:0] stat_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    logic       done = 1'b0;

    always #5 clk = ~clk;

    irq_cascade_ctrl #(.VEC_BASE(8'h20)) u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .mask_wr(mask_wr), .mask_sel(mask_sel), .mask_data(mask_data),
        .inta(inta), .eoi_pri(eoi_pri), .eoi_sec(eoi_sec),
        .stat_sel(stat_sel), .int_out(int_out), .vec_valid(vec_valid),
        .vec(vec), .stat_data(stat_data)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] expv, input string tag);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, expv);
        end
    endtask

    task automatic peek(input logic [1:0] s, input logic [15:0] expv, input string tag);
        stat_sel = s;
        #1;
        chk(stat_data, expv, tag);
    endtask

    task automatic see_int(input logic e, input string tag);
        #1;
        chk({15'd0, int_out}, {15'd0, e}, tag);
    endtask

    task automatic tick(input int n);
        @(negedge clk); irq_in[n] = 1'b1;
        @(negedge clk); irq_in[n] = 1'b0;
    endtask

    task automatic ack_push(input logic [7:0] e);
        @(negedge clk); inta = 1'b1; exp_q.push_back(e);
        @(negedge clk); inta = 1'b0;
    endtask

    task automatic eoi(input logic p, input logic s);
        @(negedge clk); eoi_pri = p; eoi_sec = s;
        @(negedge clk); eoi_pri = 1'b0; eoi_sec = 1'b0;
    endtask

    task automatic set_mask(input logic s, input logic [7:0] d);
        @(negedge clk); mask_wr = 1'b1; mask_sel = s; mask_data = d;
        @(negedge clk); mask_wr = 1'b0;
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // monitor: compare every produced vector against the scoreboard
    always @(negedge clk) begin
        if (!rst && !done && vec_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R4: unexpected vector %h expected none", vec);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (vec !== e) begin
                    n_bad++;
                    $display("FAIL R3/R4: vector got %h expected %h", vec, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        see_int(1'b0, "R1 int");
        chk({15'd0, vec_valid}, 16'd0, "R1 vec_valid");
        peek(2'd0, 16'h0000, "R1 pending");
        peek(2'd1, 16'h0000, "R1 service");
        peek(2'd2, 16'h0000, "R1 mask");

        // R2 edge latch and R4 vector
        tick(5);
        see_int(1'b1, "R2 int after edge");
        peek(2'd0, 16'h0020, "R2 pending");
        ack_push(8'h25);
        peek(2'd1, 16'h0020, "R4 service");
        peek(2'd0, 16'h0000, "R2 cleared by ack");

        // R5 preemption by a held higher line; R2 no relatch
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk);
        see_int(1'b1, "R5 higher preempts");
        ack_push(8'h23);
        @(negedge clk);
        peek(2'd0, 16'h0000, "R2 held line not relatched");
        peek(2'd1, 16'h0028, "R5 nested service");
        irq_in[3] = 1'b0;

        tick(4);
        see_int(1'b0, "R5 lower blocked");
        peek(2'd0, 16'h0010, "R5 lower pending");
        eoi(1'b1, 1'b0);
        peek(2'd1, 16'h0020, "R6 eoi clears highest");
        see_int(1'b1, "R5 unblocked");
        ack_push(8'h24);
        eoi(1'b1, 1'b0);
        eoi(1'b1, 1'b0);
        peek(2'd1, 16'h0000, "R6 all retired");

        // R3 priority across cascade
        @(negedge clk); irq_in = 16'h108A;
        @(negedge clk); irq_in = '0;
        peek(2'd0, 16'h108E, "R10 pending with cascade bit");
        ack_push(8'h21);
        eoi(1'b1, 1'b0);
        ack_push(8'h2C);
        peek(2'd1, 16'h1004, "R3 cascade service");
        peek(2'd3, 16'h0000, "R10 select 3 zero");
        see_int(1'b0, "R5 lines 3,7 below cascade");
        eoi(1'b0, 1'b1);
        see_int(1'b0, "R6 secondary eoi alone");
        peek(2'd1, 16'h0004, "R6 primary still in service");
        eoi(1'b1, 1'b0);
        see_int(1'b1, "R6 both eoi");
        ack_push(8'h23);
        eoi(1'b1, 1'b0);
        ack_push(8'h27);
        eoi(1'b1, 1'b0);

        // R7 masking
        set_mask(1'b0, 8'h01);
        peek(2'd2, 16'h0001, "R7 mask readback");
        tick(0);
        see_int(1'b0, "R7 masked silent");
        peek(2'd0, 16'h0001, "R7 masked still latched");
        set_mask(1'b0, 8'h00);
        see_int(1'b1, "R7 unmasked");
        ack_push(8'h20);
        eoi(1'b1, 1'b0);

        // R8 redirect of line 2
        set_mask(1'b1, 8'h02);
        peek(2'd2, 16'h0200, "R7 secondary mask");
        tick(2);
        see_int(1'b0, "R8 masked redirect");
        peek(2'd0, 16'h0200, "R8 status bit 9");
        set_mask(1'b1, 8'h00);
        peek(2'd0, 16'h0204, "R8 cascade asserted");
        ack_push(8'h29);
        peek(2'd1, 16'h0204, "R8 service");
        eoi(1'b1, 1'b1);
        peek(2'd1, 16'h0000, "R6 joint eoi");

        // R9 spurious
        ack_push(8'h27);
        peek(2'd1, 16'h0000, "R9 no state change");

        // R11 ack and eoi in the same cycle
        tick(6);
        ack_push(8'h26);
        tick(1);
        see_int(1'b1, "R11 higher pending");
        @(negedge clk); inta = 1'b1; eoi_pri = 1'b1; exp_q.push_back(8'h21);
        @(negedge clk); inta = 1'b0; eoi_pri = 1'b0;
        peek(2'd1, 16'h0002, "R11 merged set and clear");
        eoi(1'b1, 1'b0);
        peek(2'd1, 16'h0000, "R11 retired");

        repeat (3) @(negedge clk);
        chk(16'(exp_q.size()), 16'd0, "R4 all vectors seen");
        done = 1'b1;
        report();
    end
endmodule